// File: doc/BRIEF.md
# DRAM DLL Mode Switch Sequencer

This block sits in a DDR3-class memory controller and carries an idle device from DLL-on to DLL-off operation, or back again, with a clock frequency change in between. A single start pulse with a direction bit launches the whole run. The block then drives the command bus, the clock-enable pin and the termination pin. It asks an external clock manager to retune the clock while the device is in self refresh, and it pulses a done flag once the device can accept normal traffic again.

Turning the DLL off takes this order: a mode-register-1 write with the DLL-off bit set, self-refresh entry, the clock change, self-refresh exit, then new mode-register-0 and mode-register-2 values. Turning it on takes this order: self-refresh entry, the clock change, self-refresh exit, a mode-register-1 write that clears the DLL-off bit, and a mode-register-0 write that requests a DLL reset. Next come a mode-register-2 update and a long ZQ calibration, and the run ends only after both the calibration time and the DLL lock time have passed. Every wait is a cycle count held on an input port. NOPs fill every waiting cycle.

The caller must start the block only when the device is idle: all banks precharged, every earlier timing met, and termination off. Timing inputs must stay constant while a run is in progress.

Top module: `dll_switch_seq`

## Requirements
- R1: While reset is held and after it is released, the command is NOP (code 0), clk_en_o is 1, freq_req_o is 0, done_o is 0 and term_en_o is 0.
- R2: With to_dll_off_i=1, the commands are MRS to mode register 1 (mr_sel_o=1) carrying mr1_val_i with bit 0 forced to 1, then SRE, then SRX, then MRS to mode register 0 (mr_sel_o=0) carrying mr0_val_i with bit 8 forced to 0, then MRS to mode register 2 (mr_sel_o=2) carrying mr2_val_i unchanged.
- R3: With to_dll_off_i=0, the commands are SRE, then SRX, then MRS to mode register 1 with bit 0 forced to 0, then MRS to mode register 0 with bit 8 forced to 1, then MRS to mode register 2, then ZQCL.
- R4: A wait of n cycles means the next event comes max(n,1) cycles after the command that began it. After an MRS the wait is max(t_mod_i,t_mrd_i), except for the mode-register-1 and mode-register-0 writes of the enable run, which wait t_mrd_i.
- R5: freq_req_o rises max(t_cksre_i,t_ckesr_i) cycles after the SRE cycle. clk_en_o is 0 from the SRE cycle up to the cycle before SRX, and it is 1 in the SRX cycle and at all other times.
- R6: SRX comes max(t_cksrx_i,1)+1 cycles after the first cycle in which freq_stable_i is sampled high during an unbroken high run. If freq_stable_i drops, the count starts over.
- R7: freq_req_o stays high until the SRX cycle and is low in that cycle.
- R8: The first MRS after SRX comes max(t_xs_i,1) cycles after SRX.
- R9: In the enable run, ZQCL comes after the mode-register-2 wait, and done_o comes max(t_zqcl_i,t_dllk_i) cycles after ZQCL.
- R10: done_o is high for exactly one cycle, at the end of the final wait. In the disable run that is max(t_mod_i,t_mrd_i) cycles after the last MRS. No command follows done_o until the next start.
- R11: start_i is ignored while a run is in progress. The command stream is unchanged and no extra run follows.
- R12: Command codes are NOP=0, MRS=1, SRE=2, SRX=3, ZQCL=4. In every cycle without a command, mr_sel_o and mr_data_o are 0.
- R13: term_en_o is held low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a run when idle |
| to_dll_off_i | input | 1 | Direction of the run: 1 turns the DLL off, 0 turns it on |
| mr0_val_i | input | DATA_W | Mode register 0 value for the new mode |
| mr1_val_i | input | DATA_W | Mode register 1 value; bit 0 is overridden |
| mr2_val_i | input | DATA_W | Mode register 2 value for the new mode |
| t_mod_i | input | TIME_W | MRS-to-non-MRS delay in cycles |
| t_mrd_i | input | TIME_W | MRS-to-MRS delay in cycles |
| t_cksre_i | input | TIME_W | Clock hold after self-refresh entry |
| t_ckesr_i | input | TIME_W | Minimum clk_en_o low time |
| t_cksrx_i | input | TIME_W | Stable clock before self-refresh exit |
| t_xs_i | input | TIME_W | Self-refresh exit to first command |
| t_dllk_i | input | TIME_W | DLL lock time |
| t_zqcl_i | input | TIME_W | Long calibration time |
| freq_stable_i | input | 1 | Clock manager reports the new clock stable |
| cmd_o | output | 3 | Command code |
| mr_sel_o | output | 2 | Mode register select |
| mr_data_o | output | DATA_W | Mode register payload |
| clk_en_o | output | 1 | Device clock enable |
| term_en_o | output | 1 | On-die termination control |
| freq_req_o | output | 1 | Frequency change request |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench runs both directions. It forces the DLL bits against their incoming values, so a design that passes mr1_val_i or mr0_val_i through unchanged shows a wrong payload. One run sets every timing to zero to check the one-cycle floor, where a counter without that floor would wrap and stall. Another run picks t_mrd_i above t_mod_i so that a design using the wrong limit shifts every later event. A run with a one-cycle drop in freq_stable_i catches an exit that does not restart the stability count, because SRX then comes two cycles early. A second start pulse in mid-run, with the opposite direction, would reveal an FSM that reloads its direction or restarts.

// File: rtl/dllsw_pkg.sv
package dllsw_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_MRS  = 3'd1,
        CMD_SRE  = 3'd2,
        CMD_SRX  = 3'd3,
        CMD_ZQCL = 3'd4
    } cmd_e;

    localparam int SEL_W = 2;
    localparam logic [SEL_W-1:0] SEL_MR0 = 2'd0;
    localparam logic [SEL_W-1:0] SEL_MR1 = 2'd1;
    localparam logic [SEL_W-1:0] SEL_MR2 = 2'd2;

    // Each step names the action just issued; the FSM then waits in it.
    typedef enum logic [3:0] {
        STP_IDLE = 4'd0,
        STP_MR1  = 4'd1,
        STP_SRE  = 4'd2,
        STP_FREQ = 4'd3,
        STP_STAB = 4'd4,
        STP_SRX  = 4'd5,
        STP_MR0  = 4'd6,
        STP_MR2  = 4'd7,
        STP_ZQ   = 4'd8
    } step_e;

    // Step order for both directions; STP_IDLE as a successor means finished.
    function automatic step_e seq_next(step_e cur, logic to_off);
        case (cur)
            STP_IDLE: return to_off ? STP_MR1 : STP_SRE;
            STP_MR1:  return to_off ? STP_SRE : STP_MR0;
            STP_SRE:  return STP_FREQ;
            STP_FREQ: return STP_STAB;
            STP_STAB: return STP_SRX;
            STP_SRX:  return to_off ? STP_MR0 : STP_MR1;
            STP_MR0:  return STP_MR2;
            STP_MR2:  return to_off ? STP_IDLE : STP_ZQ;
            default:  return STP_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/dllsw_timer.sv
module dllsw_timer #(
    parameter int TIME_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [TIME_W-1:0] len_i,
    output logic              zero_o
);
    logic [TIME_W-1:0] cnt_d, cnt_q;

    // A load of n leaves n-1 so the next step fires n cycles later (n=0 acts as 1).
    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = (len_i == '0) ? '0 : len_i - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dllsw_cmd_gen.sv
module dllsw_cmd_gen
    import dllsw_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int TIME_W      = 10,
    parameter int DLL_OFF_BIT = 0,
    parameter int DLL_RST_BIT = 8
) (
    input  step_e             step_i,
    input  logic              to_off_i,
    input  logic [DATA_W-1:0] mr0_val_i,
    input  logic [DATA_W-1:0] mr1_val_i,
    input  logic [DATA_W-1:0] mr2_val_i,
    input  logic [TIME_W-1:0] t_mod_i,
    input  logic [TIME_W-1:0] t_mrd_i,
    input  logic [TIME_W-1:0] t_cksre_i,
    input  logic [TIME_W-1:0] t_ckesr_i,
    input  logic [TIME_W-1:0] t_cksrx_i,
    input  logic [TIME_W-1:0] t_xs_i,
    input  logic [TIME_W-1:0] t_dllk_i,
    input  logic [TIME_W-1:0] t_zqcl_i,
    output cmd_e              cmd_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [DATA_W-1:0] data_o,
    output logic [TIME_W-1:0] wait_o
);
    function automatic logic [TIME_W-1:0] tmax(logic [TIME_W-1:0] a, logic [TIME_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    logic [TIME_W-1:0] mrs_gap;
    assign mrs_gap = tmax(t_mod_i, t_mrd_i);

    always_comb begin
        cmd_o  = CMD_NOP;
        sel_o  = '0;
        data_o = '0;
        wait_o = '0;
        case (step_i)
            STP_MR1: begin
                cmd_o  = CMD_MRS;
                sel_o  = SEL_MR1;
                data_o = mr1_val_i;
                data_o[DLL_OFF_BIT] = to_off_i;
                wait_o = to_off_i ? mrs_gap : t_mrd_i;
            end
            STP_MR0: begin
                cmd_o  = CMD_MRS;
                sel_o  = SEL_MR0;
                data_o = mr0_val_i;
                data_o[DLL_RST_BIT] = ~to_off_i;
                wait_o = to_off_i ? mrs_gap : t_mrd_i;
            end
            STP_MR2: begin
                cmd_o  = CMD_MRS;
                sel_o  = SEL_MR2;
                data_o = mr2_val_i;
                wait_o = mrs_gap;
            end
            STP_SRE: begin
                cmd_o  = CMD_SRE;
                wait_o = tmax(t_cksre_i, t_ckesr_i);
            end
            STP_STAB: wait_o = t_cksrx_i;
            STP_SRX: begin
                cmd_o  = CMD_SRX;
                wait_o = t_xs_i;
            end
            STP_ZQ: begin
                cmd_o  = CMD_ZQCL;
                wait_o = tmax(t_zqcl_i, t_dllk_i);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dllsw_ctrl.sv
module dllsw_ctrl
    import dllsw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              to_off_i,
    input  logic              freq_stable_i,
    input  logic              zero_i,
    input  cmd_e              gen_cmd_i,
    input  logic [SEL_W-1:0]  gen_sel_i,
    input  logic [DATA_W-1:0] gen_data_i,
    output step_e             issue_step_o,
    output logic              issue_off_o,
    output logic              load_o,
    output cmd_e              cmd_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [DATA_W-1:0] data_o,
    output logic              clk_en_o,
    output logic              freq_req_o,
    output logic              done_o
);
    typedef struct packed {
        step_e             step;
        logic              to_off;
        cmd_e              cmd;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] data;
        logic              clk_en;
        logic              freq_req;
        logic              done;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  adv, drop;

    assign issue_off_o  = (st_q.step == STP_IDLE) ? to_off_i : st_q.to_off;
    assign issue_step_o = seq_next(st_q.step, issue_off_o);

    always_comb begin
        adv  = 1'b0;
        drop = 1'b0;
        case (st_q.step)
            STP_IDLE: adv = start_i;
            STP_FREQ: adv = freq_stable_i;
            STP_STAB: begin
                drop = ~freq_stable_i;
                adv  = zero_i & freq_stable_i;
            end
            default:  adv = zero_i;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.cmd  = CMD_NOP;
        st_d.sel  = '0;
        st_d.data = '0;
        st_d.done = 1'b0;
        load_o    = 1'b0;
        if (st_q.step == STP_IDLE && start_i) begin
            st_d.to_off = to_off_i;
        end
        if (drop) begin
            st_d.step = STP_FREQ;
        end else if (adv) begin
            if (issue_step_o == STP_IDLE) begin
                st_d.step = STP_IDLE;
                st_d.done = 1'b1;
            end else begin
                st_d.step = issue_step_o;
                st_d.cmd  = gen_cmd_i;
                st_d.sel  = gen_sel_i;
                st_d.data = gen_data_i;
                load_o    = 1'b1;
                if (gen_cmd_i == CMD_SRE) st_d.clk_en = 1'b0;
                if (gen_cmd_i == CMD_SRX) begin
                    st_d.clk_en   = 1'b1;
                    st_d.freq_req = 1'b0;
                end
                if (issue_step_o == STP_FREQ) st_d.freq_req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q          <= '0;
            st_q.step     <= STP_IDLE;
            st_q.cmd      <= CMD_NOP;
            st_q.clk_en   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o      = st_q.cmd;
    assign sel_o      = st_q.sel;
    assign data_o     = st_q.data;
    assign clk_en_o   = st_q.clk_en;
    assign freq_req_o = st_q.freq_req;
    assign done_o     = st_q.done;
endmodule

// File: rtl/dll_switch_seq.sv
module dll_switch_seq
    import dllsw_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int TIME_W      = 10,
    parameter int DLL_OFF_BIT = 0,
    parameter int DLL_RST_BIT = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              to_dll_off_i,
    input  logic [DATA_W-1:0] mr0_val_i,
    input  logic [DATA_W-1:0] mr1_val_i,
    input  logic [DATA_W-1:0] mr2_val_i,
    input  logic [TIME_W-1:0] t_mod_i,
    input  logic [TIME_W-1:0] t_mrd_i,
    input  logic [TIME_W-1:0] t_cksre_i,
    input  logic [TIME_W-1:0] t_ckesr_i,
    input  logic [TIME_W-1:0] t_cksrx_i,
    input  logic [TIME_W-1:0] t_xs_i,
    input  logic [TIME_W-1:0] t_dllk_i,
    input  logic [TIME_W-1:0] t_zqcl_i,
    input  logic              freq_stable_i,
    output logic [2:0]        cmd_o,
    output logic [1:0]        mr_sel_o,
    output logic [DATA_W-1:0] mr_data_o,
    output logic              clk_en_o,
    output logic              term_en_o,
    output logic              freq_req_o,
    output logic              done_o
);
    step_e             issue_step;
    logic              issue_off;
    logic              load;
    logic              zero;
    cmd_e              gen_cmd;
    logic [SEL_W-1:0]  gen_sel;
    logic [DATA_W-1:0] gen_data;
    logic [TIME_W-1:0] gen_wait;
    cmd_e              cmd_q;

    dllsw_cmd_gen #(
        .DATA_W(DATA_W), .TIME_W(TIME_W),
        .DLL_OFF_BIT(DLL_OFF_BIT), .DLL_RST_BIT(DLL_RST_BIT)
    ) i_gen (
        .step_i(issue_step), .to_off_i(issue_off),
        .mr0_val_i(mr0_val_i), .mr1_val_i(mr1_val_i), .mr2_val_i(mr2_val_i),
        .t_mod_i(t_mod_i), .t_mrd_i(t_mrd_i), .t_cksre_i(t_cksre_i),
        .t_ckesr_i(t_ckesr_i), .t_cksrx_i(t_cksrx_i), .t_xs_i(t_xs_i),
        .t_dllk_i(t_dllk_i), .t_zqcl_i(t_zqcl_i),
        .cmd_o(gen_cmd), .sel_o(gen_sel), .data_o(gen_data), .wait_o(gen_wait)
    );

    dllsw_timer #(.TIME_W(TIME_W)) i_timer (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .load_i(load), .len_i(gen_wait), .zero_o(zero)
    );

    dllsw_ctrl #(.DATA_W(DATA_W)) i_ctrl (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .start_i(start_i), .to_off_i(to_dll_off_i),
        .freq_stable_i(freq_stable_i), .zero_i(zero),
        .gen_cmd_i(gen_cmd), .gen_sel_i(gen_sel), .gen_data_i(gen_data),
        .issue_step_o(issue_step), .issue_off_o(issue_off), .load_o(load),
        .cmd_o(cmd_q), .sel_o(mr_sel_o), .data_o(mr_data_o),
        .clk_en_o(clk_en_o), .freq_req_o(freq_req_o), .done_o(done_o)
    );

    assign cmd_o = cmd_q;
    // Termination stays off for the whole procedure.
    assign term_en_o = 1'b0;
endmodule

// File: rtl/dllsw_checker.sv
module dllsw_checker
    import dllsw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [2:0]        cmd_o,
    input logic [1:0]        mr_sel_o,
    input logic [DATA_W-1:0] mr_data_o,
    input logic              clk_en_o,
    input logic              freq_req_o,
    input logic              freq_stable_i,
    input logic              done_o
);
    p_cke_fall_sre_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(clk_en_o) |-> cmd_o == CMD_SRE);

    p_cke_rise_srx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(clk_en_o) |-> cmd_o == CMD_SRX);

    p_srx_after_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_o == CMD_SRX |-> $past(freq_stable_i));

    p_req_in_self_refresh_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        freq_req_o |-> !clk_en_o);

    p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_done_quiet_bus_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> cmd_o == CMD_NOP && !freq_req_o && clk_en_o);

    p_idle_fields_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_o != CMD_MRS |-> mr_sel_o == '0 && mr_data_o == '0);
endmodule

bind dll_switch_seq dllsw_checker #(.DATA_W(DATA_W)) i_dllsw_checker (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_o(cmd_o), .mr_sel_o(mr_sel_o),
    .mr_data_o(mr_data_o), .clk_en_o(clk_en_o), .freq_req_o(freq_req_o),
    .freq_stable_i(freq_stable_i), .done_o(done_o)
);

// File: tb/test_dll_switch_seq.sv
module test_dll_switch_seq;
    localparam int DW = 16;
    localparam int TW = 10;
    localparam int K_RISE = 6;
    localparam int K_DONE = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic start = 1'b0, to_off = 1'b0, stable = 1'b0;
    logic [DW-1:0] mr0 = '0, mr1 = '0, mr2 = '0;
    logic [TW-1:0] t_mod = '0, t_mrd = '0, t_cksre = '0, t_ckesr = '0;
    logic [TW-1:0] t_cksrx = '0, t_xs = '0, t_dllk = '0, t_zqcl = '0;
    logic [2:0]    cmd;
    logic [1:0]    sel;
    logic [DW-1:0] data;
    logic clk_en, term_en, freq_req, done;

    dll_switch_seq #(.DATA_W(DW), .TIME_W(TW)) i_dll_switch_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .to_dll_off_i(to_off),
        .mr0_val_i(mr0), .mr1_val_i(mr1), .mr2_val_i(mr2),
        .t_mod_i(t_mod), .t_mrd_i(t_mrd), .t_cksre_i(t_cksre), .t_ckesr_i(t_ckesr),
        .t_cksrx_i(t_cksrx), .t_xs_i(t_xs), .t_dllk_i(t_dllk), .t_zqcl_i(t_zqcl),
        .freq_stable_i(stable), .cmd_o(cmd), .mr_sel_o(sel), .mr_data_o(data),
        .clk_en_o(clk_en), .term_en_o(term_en), .freq_req_o(freq_req), .done_o(done)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;

    typedef struct {
        int    kind;
        int    sel;
        int    data;
        int    at;
        string req;
    } exp_t;
    exp_t exp_q[$];

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    task automatic push(int kind, int s, int d, int at, string req);
        exp_t e;
        e.kind = kind; e.sel = s; e.data = d; e.at = at; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic take(int kind, int s, int d);
        exp_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R11", "unexpected event", kind, 0);
            return;
        end
        e = exp_q.pop_front();
        check(kind == e.kind, e.req, "event kind", kind, e.kind);
        check(s == e.sel && d == e.data, e.req, "mode register payload", d, e.data);
        check(cyc == e.at, e.req, "event cycle", cyc, e.at);
    endtask

    // Monitor: samples outputs in the middle of each cycle.
    bit prev_req = 1'b0, prev_done = 1'b0, in_sr = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd != 3'd0) take(int'(cmd), int'(sel), int'(data));
            else check(sel == '0 && data == '0, "R12", "fields on NOP", int'(data), 0);
            if (freq_req && !prev_req) take(K_RISE, 0, 0);
            if (done) take(K_DONE, 0, 0);
            if (prev_done) check(!done, "R10", "done width", int'(done), 0);
            if (cmd == 3'd2) in_sr = 1'b1;
            if (cmd == 3'd3) begin
                in_sr = 1'b0;
                check(!freq_req && prev_req, "R7", "request drop at SRX", int'(freq_req), 0);
            end
            check(clk_en == !in_sr, "R5", "clock enable level", int'(clk_en), int'(!in_sr));
            check(!term_en, "R13", "termination", int'(term_en), 0);
            prev_req  = freq_req;
            prev_done = done;
        end
    end

    function automatic int g1(int n);
        return (n < 1) ? 1 : n;
    endfunction
    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    int v_mod, v_mrd, v_cksre, v_ckesr, v_cksrx, v_xs, v_dllk, v_zqcl;

    task automatic set_times(int a, int b, int c, int d, int e, int f, int g, int h);
        v_mod = a; v_mrd = b; v_cksre = c; v_ckesr = d;
        v_cksrx = e; v_xs = f; v_dllk = g; v_zqcl = h;
        t_mod = TW'(a); t_mrd = TW'(b); t_cksre = TW'(c); t_ckesr = TW'(d);
        t_cksrx = TW'(e); t_xs = TW'(f); t_dllk = TW'(g); t_zqcl = TW'(h);
    endtask

    // Driver: pushes the expected schedule, then plays the clock manager.
    task automatic run(bit off, int dly, bit glitch, bit poke);
        int c0, s, f, j, x, t, gap;
        @(negedge clk);
        c0 = cyc + 1;
        start = 1'b1; to_off = off;
        gap = g1(mx(v_mod, v_mrd));
        if (off) begin
            push(1, 1, int'(mr1 | 16'h0001), c0, "R2");
            s = c0 + gap;
            push(2, 0, 0, s, "R4");
        end else begin
            s = c0;
            push(2, 0, 0, s, "R3");
        end
        f = s + g1(mx(v_cksre, v_ckesr));
        push(K_RISE, 0, 0, f, "R5");
        j = f + dly + (glitch ? 2 : 0);
        x = j + g1(v_cksrx) + 1;
        push(3, 0, 0, x, "R6");
        t = x + g1(v_xs);
        if (off) begin
            push(1, 0, int'(mr0 & 16'hFEFF), t, "R8");
            t += gap;
            push(1, 2, int'(mr2), t, "R2");
            t += gap;
            push(K_DONE, 0, 0, t, "R10");
        end else begin
            push(1, 1, int'(mr1 & 16'hFFFE), t, "R8");
            t += g1(v_mrd);
            push(1, 0, int'(mr0 | 16'h0100), t, "R4");
            t += g1(v_mrd);
            push(1, 2, int'(mr2), t, "R3");
            t += gap;
            push(4, 0, 0, t, "R9");
            t += g1(mx(v_zqcl, v_dllk));
            push(K_DONE, 0, 0, t, "R9");
        end
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R11: a second start with the other direction must change nothing.
            repeat (2) @(negedge clk);
            start = 1'b1; to_off = !off;
            @(negedge clk);
            start = 1'b0;
        end
        while (!freq_req) @(negedge clk);
        repeat (dly) @(negedge clk);
        stable = 1'b1;
        if (glitch) begin
            @(negedge clk); stable = 1'b0;
            @(negedge clk); stable = 1'b1;
        end
        while (freq_req) @(negedge clk);
        stable = 1'b0;
        while (!done) @(negedge clk);
        repeat (8) @(negedge clk);
        check(exp_q.size() == 0, "R10", "events left after done", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cmd == 3'd0 && clk_en && !freq_req && !done && !term_en,
              "R1", "outputs in reset", int'(cmd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd == 3'd0 && clk_en && !freq_req && !done,
              "R1", "outputs after reset", int'(clk_en), 1);

        // Disable run with distinct limits.
        mr0 = 16'h1D30; mr1 = 16'h0046; mr2 = 16'h0218;
        set_times(6, 4, 5, 7, 3, 9, 20, 12);
        run(1'b1, 2, 1'b0, 1'b0);

        // Enable run with an ignored start in the middle.
        mr0 = 16'h0A20; mr1 = 16'h0047; mr2 = 16'h0010;
        run(1'b0, 0, 1'b0, 1'b1);

        // Enable run: MRD above MOD, calibration above lock time, unstable clock.
        mr0 = 16'h0324; mr1 = 16'h0A05; mr2 = 16'h0008;
        set_times(3, 8, 9, 2, 4, 5, 6, 15);
        run(1'b0, 3, 1'b1, 1'b0);

        // Disable run with every limit zero: one-cycle floor on every gap.
        mr0 = 16'hFFFF; mr1 = 16'h0000; mr2 = 16'h1234;
        set_times(0, 0, 0, 0, 0, 0, 0, 0);
        run(1'b1, 0, 1'b0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule